// File: doc/BRIEF.md
# Target Data-Phase Latency Monitor

This block watches a bus transaction in which the device acts as target and enforces two wait limits. From the first clock of the transaction it counts clocks until the first data transfer completes. After each completed transfer it counts clocks until the next one completes. If the first transfer has not completed by its 16th clock, the block requests a retry. If a later transfer has not completed by the 8th clock after the previous one, the block requests a disconnect. A request is raised only on a clock where the back end has no data ready and no transfer completes.

Software can stop the automatic requests with a disable input. The disable counts for a phase only when it is seen early enough. For the first phase it must arrive no later than the 14th clock, which is the last clock before the 15th. For a later phase it must arrive no later than the 6th clock. An accepted disable lasts until the phase ends. Once a request is raised it stays up until the transaction ends.

Top module: `latency_disc_monitor`

## Requirements
- R1: After reset, and whenever no transaction is active, `retryReq` and `disconnectReq` are both low.
- R2: Clock 1 of the first phase is the first clock with `frameActive` high. If `xferDone` stays low through clock 16 and `dataReady` is low at clock 16, `retryReq` is high after the edge that ends clock 16. No request appears before that edge.
- R3: A later phase begins on the clock after a completing `xferDone`. If no completion occurs by that phase's 8th clock and `dataReady` is low there, `disconnectReq` is high after the edge that ends clock 8.
- R4: The clock count restarts on every completion. A chain of later phases that each complete on their 8th clock never raises a request.
- R5: If `latencyDisable` is high on any first-phase clock numbered 1 to 14, that phase raises no request. A disable seen first on clock 15 or later has no effect.
- R6: If `latencyDisable` is high on any later-phase clock numbered 1 to 6, that phase raises no request. A disable seen first on clock 7 or later has no effect.
- R7: An accepted disable applies only to its own phase. It is cleared when a transfer completes and when the transaction ends.
- R8: A clock at or beyond the limit where `dataReady` is high defers the request. The request is raised at the first clock at or beyond the limit where `dataReady` is low and `xferDone` is low.
- R9: The two requests are never high together. A request stays high while `frameActive` is high, even if further transfers complete. It is low after the first edge at which `frameActive` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameActive | input | 1 | High on every clock of a target transaction |
| xferDone | input | 1 | Strobe: a data transfer completes on this clock |
| dataReady | input | 1 | Back end can supply or accept data on this clock |
| latencyDisable | input | 1 | Software disable of the automatic requests |
| retryReq | output | 1 | Request raised by the first-phase limit |
| disconnectReq | output | 1 | Request raised by a later-phase limit |

## Verification
The hardest cases to reach are the disable-window edges: a disable pulse on exactly the 14th or 15th clock of the first phase, or on the 6th or 7th clock of a later phase. Reaching them needs exact control over where the phase boundary falls. The bench therefore drives every stimulus on a clock index it counts itself. It sweeps the completion clock and the single-clock disable pulse across every position of each phase. It also sweeps a back-end-ready window that straddles the limit, to confirm the request is deferred to the first eligible clock.

// File: rtl/latency_disc_pkg.sv
package latency_disc_pkg;

  // Strobes from control to the phase counter.
  typedef struct packed {
    logic clearCnt;   // restart the phase count
    logic incCnt;     // advance the phase count
    logic useFirst;   // compare against the first-phase limit
  } ctlStrobes_t;

  // Comparison results from the phase counter back to control.
  typedef struct packed {
    logic atLimit;    // current clock index is at or past the limit
    logic inWindow;   // current clock index still accepts a disable
  } dpFlags_t;

endpackage

// File: rtl/latency_disc_datapath.sv
module latency_disc_datapath
  import latency_disc_pkg::*;
#(
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8,
  parameter int DIS_LEAD    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  output dpFlags_t    flags
);

  localparam int CW      = $clog2(FIRST_LIMIT + 1);
  localparam int IW      = CW + 1;
  localparam int CNT_MAX = (FIRST_LIMIT > LATER_LIMIT) ? FIRST_LIMIT : LATER_LIMIT;

  logic [CW-1:0] cnt;
  logic [IW-1:0] curIdx;
  logic [IW-1:0] limitVal;
  logic [IW-1:0] windowEnd;

  // Clocks already spent in the phase; saturates so a held phase stays at limit.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.clearCnt) begin
      cnt <= '0;
    end else if (strb.incCnt && (cnt != CW'(CNT_MAX))) begin
      cnt <= cnt + CW'(1);
    end
  end

  always_comb begin
    curIdx    = {1'b0, cnt} + IW'(1);
    limitVal  = strb.useFirst ? IW'(FIRST_LIMIT) : IW'(LATER_LIMIT);
    windowEnd = strb.useFirst ? IW'(FIRST_LIMIT - DIS_LEAD) : IW'(LATER_LIMIT - DIS_LEAD);
    flags.atLimit  = (curIdx >= limitVal);
    flags.inWindow = (curIdx <= windowEnd);
  end

endmodule

// File: rtl/latency_disc_control.sv
module latency_disc_control
  import latency_disc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameActive,
  input  logic        xferDone,
  input  logic        dataReady,
  input  logic        latencyDisable,
  input  dpFlags_t    flags,
  output ctlStrobes_t strb,
  output logic        retryReq,
  output logic        disconnectReq
);

  logic firstPhase;
  logic suppress;
  logic reqHeld;
  logic isRetry;
  logic fire;

  always_comb begin
    strb.clearCnt = !frameActive || xferDone;
    strb.incCnt   = frameActive && !xferDone;
    strb.useFirst = firstPhase;
    fire = frameActive && !reqHeld && !xferDone && !dataReady &&
           !suppress && flags.atLimit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstPhase <= 1'b1;
      suppress   <= 1'b0;
      reqHeld    <= 1'b0;
      isRetry    <= 1'b0;
    end else if (!frameActive) begin
      firstPhase <= 1'b1;
      suppress   <= 1'b0;
      reqHeld    <= 1'b0;
      isRetry    <= 1'b0;
    end else begin
      if (xferDone) begin
        firstPhase <= 1'b0;
        suppress   <= 1'b0;
      end else if (latencyDisable && flags.inWindow) begin
        suppress <= 1'b1;
      end
      if (fire) begin
        reqHeld <= 1'b1;
        isRetry <= firstPhase;
      end
    end
  end

  assign retryReq      = reqHeld && isRetry;
  assign disconnectReq = reqHeld && !isRetry;

endmodule

// File: rtl/latency_disc_monitor.sv
module latency_disc_monitor
  import latency_disc_pkg::*;
#(
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8,
  parameter int DIS_LEAD    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic frameActive,
  input  logic xferDone,
  input  logic dataReady,
  input  logic latencyDisable,
  output logic retryReq,
  output logic disconnectReq
);

  ctlStrobes_t strb;
  dpFlags_t    flags;

  latency_disc_datapath #(
    .FIRST_LIMIT(FIRST_LIMIT),
    .LATER_LIMIT(LATER_LIMIT),
    .DIS_LEAD(DIS_LEAD)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .flags(flags)
  );

  latency_disc_control ctl_i (
    .clk(clk),
    .rstN(rstN),
    .frameActive(frameActive),
    .xferDone(xferDone),
    .dataReady(dataReady),
    .latencyDisable(latencyDisable),
    .flags(flags),
    .strb(strb),
    .retryReq(retryReq),
    .disconnectReq(disconnectReq)
  );

endmodule

// File: rtl/latency_disc_checker.sv
module latency_disc_checker #(
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8
) (
  input logic clk,
  input logic rstN,
  input logic frameActive,
  input logic xferDone,
  input logic dataReady,
  input logic retryReq,
  input logic disconnectReq
);

  logic [7:0] chkCnt;
  logic [8:0] chkIdx;
  logic       firstDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chkCnt    <= '0;
      firstDone <= 1'b0;
    end else if (!frameActive) begin
      chkCnt    <= '0;
      firstDone <= 1'b0;
    end else if (xferDone) begin
      chkCnt    <= '0;
      firstDone <= 1'b1;
    end else if (chkCnt != 8'hFF) begin
      chkCnt <= chkCnt + 8'd1;
    end
  end

  assign chkIdx = {1'b0, chkCnt} + 9'd1;

  assert_no_early_retry_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retryReq) |-> ($past(chkIdx) >= 9'(FIRST_LIMIT)) && !$past(firstDone));

  assert_no_early_disc_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(disconnectReq) |-> ($past(chkIdx) >= 9'(LATER_LIMIT)) && $past(firstDone));

  assert_backend_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(retryReq || disconnectReq) |-> $past(frameActive && !dataReady && !xferDone));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(retryReq && disconnectReq));

  assert_hold_retry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (retryReq && frameActive) |=> retryReq);

  assert_hold_disc_R9: assert property (@(posedge clk) disable iff (!rstN)
    (disconnectReq && frameActive) |=> disconnectReq);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !frameActive |=> (!retryReq && !disconnectReq));

endmodule

bind latency_disc_monitor latency_disc_checker #(
  .FIRST_LIMIT(FIRST_LIMIT),
  .LATER_LIMIT(LATER_LIMIT)
) chk_i (
  .clk(clk),
  .rstN(rstN),
  .frameActive(frameActive),
  .xferDone(xferDone),
  .dataReady(dataReady),
  .retryReq(retryReq),
  .disconnectReq(disconnectReq)
);

// File: tb/latency_disc_monitor_tb_top.sv
`timescale 1ns/1ps
module latency_disc_monitor_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameActive = 1'b0;
  logic xferDone = 1'b0;
  logic dataReady = 1'b0;
  logic latencyDisable = 1'b0;
  logic retryReq;
  logic disconnectReq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  latency_disc_monitor dut_i (
    .clk(clk),
    .rstN(rstN),
    .frameActive(frameActive),
    .xferDone(xferDone),
    .dataReady(dataReady),
    .latencyDisable(latencyDisable),
    .retryReq(retryReq),
    .disconnectReq(disconnectReq)
  );

  task automatic checkOut(input string tag, input bit expR, input bit expD);
    checks++;
    if (retryReq !== expR || disconnectReq !== expD) begin
      fails++;
      $display("FAIL %s: retry=%0b exp %0b, disconnect=%0b exp %0b at %0t",
               tag, retryReq, expR, disconnectReq, expD, $time);
    end
  endtask

  // One clock with the given inputs, then sample after the edge.
  task automatic step(input bit fr, input bit xd, input bit dr, input bit ds,
                      input string tag, input bit expR, input bit expD);
    frameActive = fr; xferDone = xd; dataReady = dr; latencyDisable = ds;
    @(posedge clk); #2;
    checkOut(tag, expR, expD);
  endtask

  task automatic endTxn(input string tag);
    step(1'b0, 1'b0, 1'b0, 1'b0, tag, 1'b0, 1'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #5;
    checkOut("R1 in reset", 1'b0, 1'b0);
    @(posedge clk); #2;
    rstN = 1'b1;
    endTxn("R1 idle after reset");
    endTxn("R1 idle");

    // R2/R3: sweep first completion clock; a stalled later phase follows.
    for (int d = 1; d <= 20; d++) begin
      for (int k = 1; k <= 26; k++)
        step(1'b1, k == d, 1'b0, 1'b0, "R2/R3 completion sweep",
             (d > 16) && (k >= 16), (d <= 16) && (k >= d + 8));
      endTxn("R9 clear after sweep");
    end

    // R4: chain of later phases each finishing on their 8th clock.
    for (int k = 1; k <= 16; k++)
      step(1'b1, k == 16, 1'b0, 1'b0, "R4 first at limit", 1'b0, 1'b0);
    for (int p = 0; p < 5; p++)
      for (int k = 1; k <= 8; k++)
        step(1'b1, k == 8, 1'b0, 1'b0, "R4 chained phases", 1'b0, 1'b0);
    for (int k = 1; k <= 8; k++)
      step(1'b1, 1'b0, 1'b0, 1'b0, "R3 stall after chain", 1'b0, k == 8);
    // R9: completions after a request do not clear it, no retry appears.
    for (int k = 1; k <= 20; k++)
      step(1'b1, k[0], 1'b0, 1'b0, "R9 hold with transfers", 1'b0, 1'b1);
    endTxn("R9 clear");
    checkOut("R1 idle after clear", 1'b0, 1'b0);

    // R5: single disable pulse swept across the first phase.
    for (int j = 1; j <= 18; j++) begin
      for (int k = 1; k <= 20; k++)
        step(1'b1, 1'b0, 1'b0, k == j, "R5 first-phase disable",
             (j > 14) && (k >= 16), 1'b0);
      endTxn("R9 clear after R5");
    end

    // R6: single disable pulse swept across a later phase.
    for (int j = 1; j <= 9; j++) begin
      step(1'b1, 1'b1, 1'b0, 1'b0, "R6 first transfer", 1'b0, 1'b0);
      for (int k = 1; k <= 10; k++)
        step(1'b1, 1'b0, 1'b0, k == j, "R6 later-phase disable",
             1'b0, (j > 6) && (k >= 8));
      endTxn("R9 clear after R6");
    end

    // R7: disable is scoped to its phase.
    for (int k = 1; k <= 5; k++)
      step(1'b1, k == 5, 1'b0, k == 2, "R7 phase one", 1'b0, 1'b0);
    for (int k = 1; k <= 8; k++)
      step(1'b1, 1'b0, 1'b0, 1'b0, "R7 disable cleared by completion", 1'b0, k == 8);
    endTxn("R9 clear");
    for (int k = 1; k <= 3; k++)
      step(1'b1, 1'b0, 1'b0, k == 2, "R7 short txn", 1'b0, 1'b0);
    endTxn("R7 end");
    for (int k = 1; k <= 16; k++)
      step(1'b1, 1'b0, 1'b0, 1'b0, "R7 disable cleared by end", k == 16, 1'b0);
    endTxn("R9 clear");

    // R8: ready window starting at the limit defers the request.
    for (int w = 0; w <= 4; w++) begin
      for (int k = 1; k <= 24; k++)
        step(1'b1, 1'b0, (k >= 16) && (k < 16 + w), 1'b0, "R8 first-phase defer",
             k >= 16 + w, 1'b0);
      endTxn("R9 clear after R8");
    end
    step(1'b1, 1'b1, 1'b0, 1'b0, "R8 first transfer", 1'b0, 1'b0);
    for (int k = 1; k <= 10; k++)
      step(1'b1, 1'b0, k == 8, 1'b0, "R8 later-phase defer", 1'b0, k >= 9);
    endTxn("R9 clear");
    // R8: ready before the limit does not postpone it.
    for (int k = 1; k <= 16; k++)
      step(1'b1, 1'b0, k < 16, 1'b0, "R8 ready before limit", k == 16, 1'b0);
    endTxn("R9 clear");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule